// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns the mode word written by a mode-register-set command into burst settings and then, for each accepted read or write, issues the column address for every beat of the burst. A controller pulses `mode_load` with the 12-bit mode word. After that, each `start` pulse carries the first column and a read/write flag. The generator steps through the burst in sequential or interleaved order and marks the final beat. For reads it raises a data-valid flag a fixed number of cycles (the CAS latency) after each beat address.

The design has three parts. A mode register checks each loaded word and keeps the last legal settings. A two-state sequencer walks the beats. A short shift pipeline delays read beats by the latency. The sequencer has two states, `ST_IDLE` and `ST_BURST`:
- **Begin** (`ST_IDLE` to `ST_BURST`): `start` without `stop`.
- **Restart** (`ST_BURST` to `ST_BURST`): `start` without `stop`.
- **Advance** (`ST_BURST` to `ST_BURST`): the beat count steps when neither `start` nor `stop` is present and the current beat is not the last.
- **Finish** (`ST_BURST` to `ST_IDLE`): the last beat is shown.
- **Abort** (`ST_BURST` to `ST_IDLE`): `stop`.

Each burst latches the settings in force on its `start` cycle. A mode load during a burst affects only later bursts.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Mode bits [2:0] set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `col_last` is high on the final beat only, and `col_valid` drops in the cycle after it unless a new burst starts.
- R2: With mode bit 3 = 0 (sequential), beat k shows the start column with its low log2(length) bits replaced by (start + k) mod length. The upper bits keep their start value.
- R3: With mode bit 3 = 1 (interleaved), beat k shows the start column with its low log2(length) bits replaced by start XOR k.
- R4: Length code 111 with sequential type is a full-page burst. It counts up through the 11-bit column space and wraps from 2047 to 0. `col_last` stays low, and the burst lasts until it is stopped.
- R5: Mode bits [6:4] = 010 set a latency of 2 and 011 set 3. `rd_valid` is high exactly that many cycles after each read beat is shown on `col_valid`. Write beats never raise `rd_valid`.
- R6: With mode bit 9 = 1, every write is a single beat with `col_last` high. Reads still use the programmed length. With bit 9 = 0, writes use the programmed length.
- R7: A loaded word is reserved if any of these holds:
  - the length code is 100, 101 or 110;
  - the latency code is neither 010 nor 011;
  - bits [8:7] or bits [11:10] are not 00;
  - length code 111 is combined with interleaved type.

  A reserved word sets `mode_err` in the following cycle and leaves the previous settings in force. A legal word clears `mode_err`.
- R8: `stop` during a burst shows no further beats: `col_valid` is low in the following cycle.
- R9: `start` during a burst abandons it, and the new start column appears as beat 0 in the next cycle. When `start` and `stop` arrive together, `stop` wins and no burst begins.
- R10: After reset no beat is valid, `rd_valid` and `mode_err` are low, and the settings are length 1, sequential, latency 2 and burst writes. The first beat of any burst appears in the cycle after the `start` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Mode-register-set strobe |
| mode_value | input | 12 | Mode word captured on `mode_load` |
| start | input | 1 | Accepted read or write command |
| start_col | input | 11 | First column of the burst |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| stop | input | 1 | Burst-terminate or precharge strobe |
| col_addr | output | 11 | Column address of the current beat |
| col_valid | output | 1 | A beat is being issued |
| col_last | output | 1 | The current beat is the final one |
| rd_valid | output | 1 | Read data expected this cycle |
| mode_err | output | 1 | The last loaded mode word was reserved |

## Verification
A wrong beat count or mask appears at once as a wrong column on the second beat of a burst, or as `col_last` landing on the wrong beat. A lost latency setting shifts every `rd_valid` pulse by one cycle, starting with the first read beat's pulse two or three cycles after it is issued. A mode register that takes a reserved word does not show on `mode_err` alone. It shows in the next burst, as a changed length or ordering. A wrong state decision shows as `col_valid` staying high one cycle too long after a last beat or a stop, or as a restart column that never appears.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    // Deepest read latency the mode word can select
    localparam int MAX_LAT = 3;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic [1:0] len_log;    // log2 of burst length for lengths 1..8
        logic       full_page;  // whole column space, sequential
        logic       interleave; // XOR ordering
        logic       lat3;       // 1: latency 3, 0: latency 2
        logic       single_wr;  // writes are one beat
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{
        len_log:    2'd0,
        full_page:  1'b0,
        interleave: 1'b0,
        lat3:       1'b0,
        single_wr:  1'b0
    };

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
    import bcg_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] value,
    output burst_cfg_t        cfg,
    output logic              err
);

    logic [2:0] len_code;
    logic [2:0] lat_code;
    logic       len_ok;
    logic       lat_ok;
    logic       pad_ok;
    logic       combo_ok;
    logic       word_ok;
    burst_cfg_t cfg_new;

    always_comb begin
        len_code = value[2:0];
        lat_code = value[6:4];
        len_ok   = (len_code[2] == 1'b0) || (len_code == 3'b111);
        lat_ok   = (lat_code == 3'b010) || (lat_code == 3'b011);
        pad_ok   = (value[8:7] == 2'b00) && (value[MODE_W-1:10] == '0);
        combo_ok = !((len_code == 3'b111) && value[3]);
        word_ok  = len_ok && lat_ok && pad_ok && combo_ok;

        cfg_new.len_log    = len_code[1:0];
        cfg_new.full_page  = (len_code == 3'b111);
        cfg_new.interleave = value[3];
        cfg_new.lat3       = lat_code[0];
        cfg_new.single_wr  = value[9];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
            err <= 1'b0;
        end else if (load) begin
            err <= !word_ok;
            if (word_ok) begin
                cfg <= cfg_new;
            end
        end
    end

endmodule

// File: rtl/bcg_sequencer.sv
module bcg_sequencer
    import bcg_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  burst_cfg_t       cfg,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic             stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             rd_issue,
    output logic             lat3
);

    localparam logic [COL_W-1:0] ONE  = COL_W'(1);
    localparam logic [COL_W-1:0] ONES = '1;

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             inter_q;
    logic             is_rd_q;
    logic             lat3_q;

    logic             load_new;
    logic             single;
    logic [COL_W-1:0] mask_new;
    logic             at_last;

    always_comb begin
        load_new = start && !stop;
        single   = start_wr && cfg.single_wr;
        if (single) begin
            mask_new = '0;
        end else if (cfg.full_page) begin
            mask_new = ONES;
        end else begin
            mask_new = (ONE << cfg.len_log) - ONE;
        end
        at_last = !full_q && (beat_q == mask_q);
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_new) state_d = ST_BURST;   // begin
            end
            ST_BURST: begin
                if (stop)          state_d = ST_IDLE;   // abort
                else if (start)    state_d = ST_BURST;  // restart
                else if (at_last)  state_d = ST_IDLE;   // finish
                else               state_d = ST_BURST;  // advance
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            inter_q <= 1'b0;
            is_rd_q <= 1'b0;
            lat3_q  <= 1'b0;
        end else if (load_new) begin
            base_q  <= start_col;
            beat_q  <= '0;
            mask_q  <= mask_new;
            full_q  <= cfg.full_page && !single;
            inter_q <= cfg.interleave;
            is_rd_q <= !start_wr;
            lat3_q  <= cfg.lat3;
        end else if (state_q == ST_BURST) begin
            beat_q  <= beat_q + ONE;
        end
    end

    // outputs
    always_comb begin
        col_valid = (state_q == ST_BURST);
        if (inter_q) begin
            col_addr = (base_q & ~mask_q) | ((base_q ^ beat_q) & mask_q);
        end else begin
            col_addr = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
        end
        col_last = col_valid && at_last;
        rd_issue = col_valid && is_rd_q;
        lat3     = lat3_q;
    end

endmodule

// File: rtl/bcg_rd_delay.sv
module bcg_rd_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic sel_deep,
    output logic rd_valid
);

    logic [DEPTH-1:0] pipe;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= 1'b0;
                else        pipe[0] <= issue;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= 1'b0;
                else        pipe[i] <= pipe[i-1];
            end
        end
    end

    assign rd_valid = sel_deep ? pipe[DEPTH-1] : pipe[DEPTH-2];

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import bcg_pkg::*;
#(
    parameter int COL_W  = 11,
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_value,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_wr,
    input  logic              stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last,
    output logic              rd_valid,
    output logic              mode_err
);

    burst_cfg_t cfg;
    logic       rd_issue;
    logic       lat3;

    bcg_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .value (mode_value),
        .cfg   (cfg),
        .err   (mode_err)
    );

    bcg_sequencer #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .start     (start),
        .start_col (start_col),
        .start_wr  (start_wr),
        .stop      (stop),
        .col_addr  (col_addr),
        .col_valid (col_valid),
        .col_last  (col_last),
        .rd_issue  (rd_issue),
        .lat3      (lat3)
    );

    bcg_rd_delay #(.DEPTH(MAX_LAT)) u_rdly (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (rd_issue),
        .sel_deep (lat3),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
    parameter int COL_W  = 11,
    parameter int MODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_load,
    input logic [MODE_W-1:0] mode_value,
    input logic              start,
    input logic [COL_W-1:0]  start_col,
    input logic              stop,
    input logic [COL_W-1:0]  col_addr,
    input logic              col_valid,
    input logic              col_last,
    input logic              rd_valid,
    input logic              rd_issue,
    input logic              mode_err
);

    // R1: nothing is issued after a final beat unless a new burst begins
    assert_end_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_last && (!start || stop)) |=> !col_valid);

    // R8: a stop ends the burst in the next cycle
    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !col_valid);

    // R9: an accepted start shows its column as the next beat
    assert_start_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> (col_valid && (col_addr == $past(start_col))));

    // R7: nonzero pad bits are flagged
    assert_pad_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && (mode_value[8:7] != 2'b00)) |=> mode_err);

    // R5: read-valid only follows a read beat by two or three cycles
    assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_issue, 2) || $past(rd_issue, 3)));

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_load  (mode_load),
    .mode_value (mode_value),
    .start      (start),
    .start_col  (start_col),
    .stop       (stop),
    .col_addr   (col_addr),
    .col_valid  (col_valid),
    .col_last   (col_last),
    .rd_valid   (rd_valid),
    .rd_issue   (rd_issue),
    .mode_err   (mode_err)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_load;
    logic [11:0] mode_value;
    logic        start;
    logic [10:0] start_col;
    logic        start_wr;
    logic        stop;
    logic [10:0] col_addr;
    logic        col_valid;
    logic        col_last;
    logic        rd_valid;
    logic        mode_err;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sdram_burst_colgen dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_value(mode_value),
        .start(start), .start_col(start_col), .start_wr(start_wr), .stop(stop),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
        .rd_valid(rd_valid), .mode_err(mode_err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // len = 0 stands for full page
    function automatic logic [10:0] exp_col(input logic [10:0] s, input int beat, input int len, input bit inter);
        logic [10:0] m;
        logic [10:0] b;
        m = (len == 0) ? 11'h7FF : 11'(len - 1);
        b = 11'(beat);
        if (inter) return (s & ~m) | ((s ^ b) & m);
        else       return (s & ~m) | ((s + b) & m);
    endfunction

    task automatic load_mode(input logic [11:0] v);
        @(negedge clk);
        mode_load  = 1'b1;
        mode_value = v;
        @(negedge clk);
        mode_load  = 1'b0;
    endtask

    task automatic pulse_start(input logic [10:0] c, input bit wr);
        @(negedge clk);
        start = 1'b1; start_col = c; start_wr = wr;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_burst(input logic [10:0] c, input bit wr, input int len, input bit inter,
                             input int beats, input string req);
        pulse_start(c, wr);
        for (int b = 0; b < beats; b++) begin
            chk(col_valid === 1'b1, req, "valid", col_valid, 1);
            chk(col_addr === exp_col(c, b, len, inter), req, "col", col_addr, exp_col(c, b, len, inter));
            chk(col_last === (b == beats - 1), req, "last", col_last, (b == beats - 1));
            if (b < beats - 1) @(negedge clk);
        end
        @(negedge clk);
        chk(col_valid === 1'b0, req, "idle after last", col_valid, 0);
    endtask

    task automatic t_reset;
        chk(col_valid === 1'b0, "R10", "reset valid", col_valid, 0);
        chk(rd_valid === 1'b0, "R10", "reset rd_valid", rd_valid, 0);
        chk(mode_err === 1'b0, "R10", "reset err", mode_err, 0);
        run_burst(11'd77, 1'b0, 1, 1'b0, 1, "R10");
    endtask

    task automatic t_lengths;
        load_mode(12'h021); run_burst(11'd5, 1'b0, 2, 1'b0, 2, "R1");
        load_mode(12'h022); run_burst(11'd6, 1'b0, 4, 1'b0, 4, "R2");
        load_mode(12'h023); run_burst(11'd13, 1'b1, 8, 1'b0, 8, "R2");
        load_mode(12'h020); run_burst(11'd300, 1'b0, 1, 1'b0, 1, "R1");
    endtask

    task automatic t_interleave;
        load_mode(12'h02B); run_burst(11'd13, 1'b0, 8, 1'b1, 8, "R3");
        load_mode(12'h02A); run_burst(11'd518, 1'b1, 4, 1'b1, 4, "R3");
    endtask

    task automatic t_fullpage;
        load_mode(12'h027);
        pulse_start(11'd2045, 1'b0);
        for (int b = 0; b < 6; b++) begin
            chk(col_valid === 1'b1, "R4", "fp valid", col_valid, 1);
            chk(col_addr === exp_col(11'd2045, b, 0, 1'b0), "R4", "fp col", col_addr, exp_col(11'd2045, b, 0, 1'b0));
            chk(col_last === 1'b0, "R4", "fp last", col_last, 0);
            if (b < 5) @(negedge clk);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(col_valid === 1'b0, "R8", "stop ends full page", col_valid, 0);
    endtask

    task automatic lat_case(input logic [11:0] v, input int lat, input bit wr, input string req);
        load_mode(v);
        pulse_start(11'd20, wr);
        for (int k = 0; k < 7; k++) begin
            bit e;
            e = !wr && (k >= lat) && (k <= lat + 1);
            chk(rd_valid === e, req, "rd_valid", rd_valid, e);
            @(negedge clk);
        end
    endtask

    task automatic t_latency;
        lat_case(12'h031, 3, 1'b0, "R5");
        lat_case(12'h021, 2, 1'b0, "R5");
        lat_case(12'h021, 2, 1'b1, "R5");
    endtask

    task automatic t_single_write;
        load_mode(12'h223);
        run_burst(11'd40, 1'b1, 1, 1'b0, 1, "R6");
        run_burst(11'd41, 1'b0, 8, 1'b0, 8, "R6");
    endtask

    task automatic t_reserved;
        load_mode(12'h022);
        chk(mode_err === 1'b0, "R7", "legal err", mode_err, 0);
        load_mode(12'h024);
        chk(mode_err === 1'b1, "R7", "len code err", mode_err, 1);
        load_mode(12'h02F);
        chk(mode_err === 1'b1, "R7", "fp interleave err", mode_err, 1);
        load_mode(12'h0A2);
        chk(mode_err === 1'b1, "R7", "pad err", mode_err, 1);
        load_mode(12'h012);
        chk(mode_err === 1'b1, "R7", "latency err", mode_err, 1);
        load_mode(12'h822);
        chk(mode_err === 1'b1, "R7", "top bits err", mode_err, 1);
        run_burst(11'd9, 1'b0, 4, 1'b0, 4, "R7");
        load_mode(12'h021);
        chk(mode_err === 1'b0, "R7", "err cleared", mode_err, 0);
    endtask

    task automatic t_restart;
        load_mode(12'h023);
        pulse_start(11'd8, 1'b0);
        chk(col_addr === 11'd8, "R9", "first burst", col_addr, 8);
        @(negedge clk);
        start = 1'b1; start_col = 11'd40;
        @(negedge clk);
        start = 1'b0;
        chk(col_valid === 1'b1 && col_addr === 11'd40, "R9", "restart col", col_addr, 40);
        start = 1'b1; stop = 1'b1; start_col = 11'd99;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk(col_valid === 1'b0, "R9", "stop beats start", col_valid, 0);
    endtask

    initial begin
        rst_n = 1'b0; mode_load = 1'b0; mode_value = '0; start = 1'b0;
        start_col = '0; start_wr = 1'b0; stop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_lengths;
        t_interleave;
        t_fullpage;
        t_latency;
        t_single_write;
        t_reserved;
        t_restart;
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule